// File: doc/BRIEF.md
# Processor Halt and Wakeup Controller

This block sits next to a small 16-bit processor core and manages its low-power halt state. When the instruction decoder signals that a halt instruction has executed, the controller stalls the core, records where execution should continue, lets the halt instruction finish over a fixed number of cycles, and then switches the core clock off. The wakeup logic runs on the free-running clock, so it keeps watching for wake events while the core clock is off.

Three event sources end the halt: a maskable interrupt request, a non-maskable interrupt and a debug interrupt. The interrupt mask plays no part in waking. It only decides what the core does next. A masked request makes the core continue at the instruction after the halt. An enabled request, a non-maskable interrupt or a debug interrupt makes the core enter a handler, with the saved return address pointing after the halt. The controller turns the core clock back on one cycle before it pulses the strobe that tells the core how to resume.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, core_clk_en_o is 1, stall_o is 0, resume_o and take_irq_o are 0 and ret_addr_o is 0. Asserting reset during a halt returns the block to running with no resume or take strobe afterwards.
- R2: A halt strobe sampled while running (stall_o low) raises stall_o from the next cycle, and ret_addr_o becomes the halt address plus 2, modulo 2^ADDR_W, from that same cycle.
- R3: After an accepted halt, core_clk_en_o stays 1 for ENTRY_CYCLES (default 6) cycles, counted from the cycle after the accepting edge. It then falls to 0 if no wake event has been seen.
- R4: A one-cycle pulse on irq_req_i, nmi_i or dbg_irq_i ends the halt whatever the value of irq_enabled_i. A pulse that arrives during the entry cycles is held and acted on when the entry cycles end.
- R5: Let E be the edge that samples the wake pulse, or the last entry edge if that comes later. core_clk_en_o is 1 from the cycle after E. A single-cycle resume_o or take_irq_o follows one cycle later, and in that cycle stall_o is already 0.
- R6: When the only wake source is a maskable request with irq_enabled_i low, resume_o pulses and take_irq_o stays 0.
- R7: For any other wake, take_irq_o pulses with irq_cause_o naming the source. The codes are debug = 2, non-maskable = 1, maskable = 0. Debug wins over non-maskable, and non-maskable wins over an enabled maskable request.
- R8: A halt strobe sampled while stall_o is high is ignored. ret_addr_o and the timing of the halt in progress do not change.
- R9: resume_o and take_irq_o are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_strobe_i | input | 1 | Decoder pulse: a halt instruction has executed |
| halt_pc_i | input | ADDR_W | Address of the halt instruction |
| irq_req_i | input | 1 | Raw maskable interrupt request |
| irq_enabled_i | input | 1 | Global enable AND controller enable for the request |
| nmi_i | input | 1 | Non-maskable interrupt |
| dbg_irq_i | input | 1 | Debug interrupt |
| core_clk_en_o | output | 1 | Core clock enable |
| stall_o | output | 1 | Core is held (entry, halted or waking) |
| resume_o | output | 1 | Continue at the instruction after the halt |
| take_irq_o | output | 1 | Vector to the handler given by irq_cause_o |
| irq_cause_o | output | 2 | Handler selector, valid with take_irq_o |
| ret_addr_o | output | ADDR_W | Saved return address |

## Verification
The bench sweeps the arrival cycle of a single wake pulse from the first entry cycle to several cycles into the halted state. This shows whether an early event is held to the end of entry rather than cutting entry short, and whether a late event wakes the core on the following edge. Each arrival cycle is tried with six source mixes: a masked request, an enabled request, non-maskable alone, debug alone, non-maskable together with a request, and all three together. These separate the resume path from the handler path and check the priority order. Halt addresses near the top of the address range test the wrap of the return address. A second halt strobe sent during entry checks that it is ignored, and reset applied mid-halt checks that no strobe follows.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_ENTRY   = 2'd1,
    ST_HALTED  = 2'd2,
    ST_WAKE    = 2'd3
  } hw_state_t;

  localparam logic [1:0] CAUSE_MASKABLE = 2'd0;
  localparam logic [1:0] CAUSE_NMI      = 2'd1;
  localparam logic [1:0] CAUSE_DEBUG    = 2'd2;

  typedef struct packed {
    logic dbg;
    logic nmi;
    logic irq_on;
    logic irq_any;
  } wake_src_t;

endpackage

// File: rtl/hw_entry_timer.sv
module hw_entry_timer #(
  parameter int ENTRY_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(ENTRY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(ENTRY_CYCLES);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (run_i && cnt_q != ONE) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == ONE);
endmodule

// File: rtl/hw_wake_latch.sv
module hw_wake_latch
  import halt_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture_i,
  input  logic      clear_i,
  input  wake_src_t live_i,
  output wake_src_t pend_o,
  output logic      any_o
);
  wake_src_t pend_q, pend_d;
  logic      pend_en;

  always_comb begin
    pend_en = capture_i | clear_i;
    pend_d  = clear_i ? wake_src_t'('0) : (pend_q | live_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign any_o  = |(pend_q | live_i);
endmodule

// File: rtl/hw_wake_arbiter.sv
module hw_wake_arbiter
  import halt_wake_pkg::*;
(
  input  wake_src_t pend_i,
  output logic      take_o,
  output logic      resume_o,
  output logic [1:0] cause_o
);
  always_comb begin
    take_o   = 1'b0;
    resume_o = 1'b0;
    cause_o  = CAUSE_MASKABLE;
    if (pend_i.dbg) begin
      take_o  = 1'b1;
      cause_o = CAUSE_DEBUG;
    end else if (pend_i.nmi) begin
      take_o  = 1'b1;
      cause_o = CAUSE_NMI;
    end else if (pend_i.irq_on) begin
      take_o  = 1'b1;
      cause_o = CAUSE_MASKABLE;
    end else if (pend_i.irq_any) begin
      resume_o = 1'b1;
    end
  end
endmodule

// File: rtl/hw_ret_addr.sv
module hw_ret_addr #(
  parameter int ADDR_W   = 16,
  parameter int INSN_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] ret_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_LEN);

  logic [ADDR_W-1:0] ret_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_q <= '0;
    else if (load_i) ret_q <= pc_i + STEP;
  end

  assign ret_o = ret_q;
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int ENTRY_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_strobe_i,
  input  logic [ADDR_W-1:0] halt_pc_i,
  input  logic              irq_req_i,
  input  logic              irq_enabled_i,
  input  logic              nmi_i,
  input  logic              dbg_irq_i,
  output logic              core_clk_en_o,
  output logic              stall_o,
  output logic              resume_o,
  output logic              take_irq_o,
  output logic [1:0]        irq_cause_o,
  output logic [ADDR_W-1:0] ret_addr_o
);
  hw_state_t state_q, state_d;
  wake_src_t live, pend;
  logic      accept, entry_done, wake_any;
  logic      arb_take, arb_resume;
  logic [1:0] arb_cause;
  logic      take_q, resume_q;
  logic [1:0] cause_q;
  logic      leave_wake;

  assign live.dbg     = dbg_irq_i;
  assign live.nmi     = nmi_i;
  assign live.irq_on  = irq_req_i & irq_enabled_i;
  assign live.irq_any = irq_req_i;

  assign accept     = (state_q == ST_RUN) && halt_strobe_i;
  assign leave_wake = (state_q == ST_WAKE);

  hw_entry_timer #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .run_i  (state_q == ST_ENTRY),
    .done_o (entry_done)
  );

  hw_wake_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i ((state_q == ST_ENTRY) || (state_q == ST_HALTED)),
    .clear_i   (leave_wake),
    .live_i    (live),
    .pend_o    (pend),
    .any_o     (wake_any)
  );

  hw_wake_arbiter u_arb (
    .pend_i   (pend),
    .take_o   (arb_take),
    .resume_o (arb_resume),
    .cause_o  (arb_cause)
  );

  hw_ret_addr #(.ADDR_W(ADDR_W), .INSN_LEN(2)) u_ret (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .pc_i   (halt_pc_i),
    .ret_o  (ret_addr_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (halt_strobe_i) state_d = ST_ENTRY;
      ST_ENTRY:  if (entry_done)    state_d = wake_any ? ST_WAKE : ST_HALTED;
      ST_HALTED: if (wake_any)      state_d = ST_WAKE;
      ST_WAKE:                      state_d = ST_RUN;
      default:                      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q   <= 1'b0;
      resume_q <= 1'b0;
      cause_q  <= CAUSE_MASKABLE;
    end else begin
      take_q   <= leave_wake & arb_take;
      resume_q <= leave_wake & arb_resume;
      if (leave_wake) cause_q <= arb_cause;
    end
  end

  assign core_clk_en_o = (state_q != ST_HALTED);
  assign stall_o       = (state_q != ST_RUN);
  assign resume_o      = resume_q;
  assign take_irq_o    = take_q;
  assign irq_cause_o   = cause_q;
endmodule

// File: rtl/halt_wake_ctrl_checker.sv
module halt_wake_ctrl_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_strobe_i,
  input logic              core_clk_en_o,
  input logic              stall_o,
  input logic              resume_o,
  input logic              take_irq_o,
  input logic [1:0]        irq_cause_o,
  input logic [ADDR_W-1:0] ret_addr_o
);
  p_halt_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_strobe_i && !stall_o) |=> stall_o);

  p_clock_off_only_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en_o |-> stall_o);

  p_clock_before_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_o || take_irq_o) |-> ($past(core_clk_en_o) && $past(stall_o) && !stall_o));

  p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_o, take_irq_o}));

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_o || take_irq_o) |=> !(resume_o || take_irq_o));

  p_ret_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && $past(stall_o)) |-> $stable(ret_addr_o));

  p_cause_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> (irq_cause_o != 2'd3));
endmodule

bind halt_wake_ctrl halt_wake_ctrl_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .halt_strobe_i (halt_strobe_i),
  .core_clk_en_o (core_clk_en_o),
  .stall_o       (stall_o),
  .resume_o      (resume_o),
  .take_irq_o    (take_irq_o),
  .irq_cause_o   (irq_cause_o),
  .ret_addr_o    (ret_addr_o)
);

// File: tb/test_halt_wake_ctrl.sv
module test_halt_wake_ctrl;
  localparam int AW = 16;
  localparam int EC = 6;

  logic          clk;
  logic          rst_n;
  logic          halt_strobe_i;
  logic [AW-1:0] halt_pc_i;
  logic          irq_req_i, irq_enabled_i, nmi_i, dbg_irq_i;
  logic          core_clk_en_o, stall_o, resume_o, take_irq_o;
  logic [1:0]    irq_cause_o;
  logic [AW-1:0] ret_addr_o;

  int n_cmp;
  int n_bad;
  bit finished;

  halt_wake_ctrl #(.ADDR_W(AW), .ENTRY_CYCLES(EC)) i_halt_wake_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_strobe_i (halt_strobe_i),
    .halt_pc_i     (halt_pc_i),
    .irq_req_i     (irq_req_i),
    .irq_enabled_i (irq_enabled_i),
    .nmi_i         (nmi_i),
    .dbg_irq_i     (dbg_irq_i),
    .core_clk_en_o (core_clk_en_o),
    .stall_o       (stall_o),
    .resume_o      (resume_o),
    .take_irq_o    (take_irq_o),
    .irq_cause_o   (irq_cause_o),
    .ret_addr_o    (ret_addr_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clear_src();
    irq_req_i = 1'b0; irq_enabled_i = 1'b0; nmi_i = 1'b0; dbg_irq_i = 1'b0;
  endtask

  // pat: 0 masked irq, 1 enabled irq, 2 nmi, 3 dbg, 4 nmi+irq, 5 dbg+nmi+irq
  task automatic set_src(input int pat);
    irq_req_i     = (pat == 0 || pat == 1 || pat >= 4);
    irq_enabled_i = (pat == 1 || pat >= 4);
    nmi_i         = (pat == 2 || pat >= 4);
    dbg_irq_i     = (pat == 3 || pat == 5);
  endtask

  task automatic run_case(input logic [AW-1:0] pc, input int w, input int pat,
                          input bit second_halt);
    int wake_edge;
    logic [AW-1:0] exp_ret;
    logic exp_take, exp_res;
    logic [1:0] exp_cause;
    wake_edge = (w > EC) ? w : EC;
    exp_ret   = pc + AW'(2);
    exp_take  = (pat != 0);
    exp_res   = (pat == 0);
    exp_cause = (pat == 3 || pat == 5) ? 2'd2 : ((pat == 2 || pat == 4) ? 2'd1 : 2'd0);
    halt_strobe_i = 1'b1;
    halt_pc_i     = pc;
    @(posedge clk);
    @(negedge clk);
    halt_strobe_i = 1'b0;
    for (int t = 0; t <= wake_edge + 2; t++) begin
      clear_src();
      halt_strobe_i = 1'b0;
      if (t == w - 1) set_src(pat);
      if (second_halt && t == 2) begin
        halt_strobe_i = 1'b1;
        halt_pc_i     = pc ^ AW'(16'h5A5A);
      end
      // R2 / R8: stall and saved address
      check("R2", "stall", stall_o, (t <= wake_edge));
      check(second_halt ? "R8" : "R2", "ret_addr", ret_addr_o, exp_ret);
      // R3 / R5: clock enable window
      check((t < EC) ? "R3" : "R5", "clk_en", core_clk_en_o, !(t >= EC && t < wake_edge));
      // R4 / R6 / R7 / R9: strobes
      check(exp_res ? "R6" : "R7", "resume", resume_o, exp_res && (t == wake_edge + 1));
      check(exp_res ? "R6" : "R7", "take", take_irq_o, exp_take && (t == wake_edge + 1));
      if (t == wake_edge + 1 && exp_take)
        check("R7", "cause", irq_cause_o, exp_cause);
      if (t == wake_edge + 2)
        check("R9", "strobe_gone", resume_o | take_irq_o, 1'b0);
      if (t == wake_edge + 1)
        check("R4", "woke", stall_o, 1'b0);
      @(posedge clk);
      @(negedge clk);
    end
    clear_src();
    halt_strobe_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; finished = 0;
    rst_n = 1'b0;
    halt_strobe_i = 1'b0;
    halt_pc_i = '0;
    clear_src();
    #1;
    check("R1", "clk_en_rst", core_clk_en_o, 1'b1);
    check("R1", "stall_rst", stall_o, 1'b0);
    check("R1", "strobes_rst", {resume_o, take_irq_o}, 2'b00);
    check("R1", "ret_rst", ret_addr_o, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "clk_en_after", core_clk_en_o, 1'b1);
    check("R1", "stall_after", stall_o, 1'b0);

    for (int pat = 0; pat < 6; pat++)
      for (int w = 1; w <= EC + 4; w++)
        run_case(AW'(16'h1000 + pat * 64 + w * 2), w, pat, 1'b0);

    run_case(16'hFFFE, 3, 2, 1'b0);
    run_case(16'hFFFF, 9, 0, 1'b0);
    run_case(16'h0420, 2, 1, 1'b1);
    run_case(16'h0860, 8, 3, 1'b1);

    // R1: reset mid-halt, no strobe afterwards
    halt_strobe_i = 1'b1;
    halt_pc_i = 16'h2222;
    @(posedge clk);
    @(negedge clk);
    halt_strobe_i = 1'b0;
    repeat (EC + 2) @(negedge clk);
    check("R1", "halted_before_rst", core_clk_en_o, 1'b0);
    nmi_i = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1", "clk_en_midrst", core_clk_en_o, 1'b1);
    check("R1", "stall_midrst", stall_o, 1'b0);
    check("R1", "ret_midrst", ret_addr_o, '0);
    @(negedge clk);
    nmi_i = 1'b0;
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1", "no_strobe_after_rst", {resume_o, take_irq_o, stall_o}, 3'b000);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule